// File: doc/BRIEF.md
# Clean/Dirty Partitioned Victim Selector

This block manages replacement for one 16-way set of a last-level cache whose ways are split, logically only, into a clean group and a dirty group. A line's dirty flag alone decides which group it belongs to. Lines stay in their physical ways. The block holds the per-way valid and dirty flags and the per-way recency ranks of the set. It names a victim way combinationally from the access type and a target dirty-group size. The target comes from a sizing predictor outside the block.

On every request the block either records a hit or fills the named victim. A hit makes the touched way the most recent, and a write hit also marks that way dirty. A fill occupies the victim way and makes it the most recent. Group sizes are brought towards the target only when a new line is placed; a write hit never causes an eviction. Tag comparison, data storage, writeback paths and the predictor are outside this block.

Top module: `psel_top`

## Requirements
- R1: After reset every way is invalid and clean, and the rank of way i is i. Rank 0 is most recent and rank 15 is least recent; way i's rank is on `rank_o[4i+3:4i]`.
- R2: While any way is invalid, `victim_o` is the lowest-numbered invalid way, whatever the access type and target.
- R3: With all ways valid, if the dirty-line count is greater than `target_i`, the victim is the dirty way with the highest rank.
- R4: With all ways valid, if the dirty-line count is less than `target_i`, the victim is the clean way with the highest rank.
- R5: With all ways valid and the dirty count equal to `target_i`, a read (`req_write_i`=0) picks the highest-ranked clean way and a write picks the highest-ranked dirty way.
- R6: If the group chosen by R3 to R5 has no lines, the victim is the highest-ranked way of the other group.
- R7: A request with `req_hit_i`=1 gives way `req_way_i` rank 0 in the next cycle. Each way whose rank was lower than that way's old rank goes up by one. All other ranks keep their values.
- R8: A write hit sets only the dirty flag of the hit way, even when the dirty count then exceeds the target. No valid flag and no other dirty flag changes.
- R9: A request with `req_hit_i`=0 fills the way shown on `victim_o` in that cycle. That way becomes valid, its dirty flag equals `req_write_i`, and it takes rank 0 with the ranks updated as in R7.
- R10: `dirty_cnt_o` equals the number of ways that are both valid and dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en_i | input | 1 | A request is applied this cycle |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_hit_i | input | 1 | 1 = hit on req_way_i, 0 = miss (fill victim) |
| req_way_i | input | 4 | Way that hit |
| target_i | input | 5 | Target dirty-group size, 0 to 16 |
| victim_o | output | 4 | Chosen replacement way |
| valid_o | output | 16 | Per-way valid flags |
| dirty_o | output | 16 | Per-way dirty flags |
| rank_o | output | 64 | Per-way recency ranks, 4 bits each |
| dirty_cnt_o | output | 5 | Count of valid dirty ways |

## Verification
The bench first fills an empty set and checks that the fill order is the lowest-invalid-first order. A design that looked at partitions before the invalid ways would evict live data. It sweeps the target across, below and exactly onto the dirty count for both access types, where an inverted compare or a missing tie rule picks the wrong group. It drives sets that are all clean and all dirty, where a missing fallback would return a way outside the chosen group or a stale index. Write hits on clean lines with a low target check that the design neither evicts nor drops a valid flag. Each hit checks the full rank vector, which exposes a shift that ignores the old rank or leaves two ways with the same rank.

// File: rtl/psel_pkg.sv
package psel_pkg;
    localparam int WAYS   = 16;
    localparam int RANK_W = $clog2(WAYS);
    localparam int CNT_W  = $clog2(WAYS + 1);

    typedef logic [WAYS-1:0]               way_mask_t;
    typedef logic [RANK_W-1:0]             way_idx_t;
    typedef logic [CNT_W-1:0]              way_cnt_t;
    typedef logic [WAYS-1:0][RANK_W-1:0]   rank_vec_t;

    typedef enum logic {
        GRP_CLEAN = 1'b0,
        GRP_DIRTY = 1'b1
    } grp_e;

    typedef struct packed {
        logic     en;
        logic     write;
        logic     hit;
        way_idx_t way;
    } req_t;

    function automatic way_cnt_t ones_of(way_mask_t m);
        way_cnt_t n;
        n = '0;
        for (int i = 0; i < WAYS; i++) begin
            n = n + way_cnt_t'(m[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/psel_rank_keeper.sv
module psel_rank_keeper
    import psel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      touch_en,
    input  way_idx_t  touch_way,
    output rank_vec_t ranks
);
    rank_vec_t ranks_q;
    rank_vec_t ranks_d;
    way_idx_t  old_rank;

    always_comb begin
        old_rank = ranks_q[touch_way];
        ranks_d  = ranks_q;
        if (touch_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (ranks_q[i] < old_rank) begin
                    ranks_d[i] = ranks_q[i] + way_idx_t'(1);
                end
            end
            ranks_d[touch_way] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++) begin
                ranks_q[i] <= way_idx_t'(i);
            end
        end else begin
            ranks_q <= ranks_d;
        end
    end

    assign ranks = ranks_q;
endmodule

// File: rtl/psel_oldest_pick.sv
module psel_oldest_pick
    import psel_pkg::*;
(
    input  way_mask_t members,
    input  rank_vec_t ranks,
    output way_idx_t  oldest,
    output logic      any
);
    way_idx_t best_rank;

    always_comb begin
        oldest    = '0;
        best_rank = '0;
        any       = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (members[i] && (!any || ranks[i] > best_rank)) begin
                oldest    = way_idx_t'(i);
                best_rank = ranks[i];
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psel_group_choose.sv
module psel_group_choose
    import psel_pkg::*;
(
    input  way_cnt_t dirty_cnt,
    input  way_cnt_t target,
    input  logic     is_write,
    input  logic     clean_any,
    input  logic     dirty_any,
    output grp_e     grp
);
    grp_e wanted;

    always_comb begin
        if (dirty_cnt > target) begin
            wanted = GRP_DIRTY;
        end else if (dirty_cnt < target) begin
            wanted = GRP_CLEAN;
        end else begin
            wanted = is_write ? GRP_DIRTY : GRP_CLEAN;
        end

        grp = wanted;
        if (wanted == GRP_DIRTY && !dirty_any) begin
            grp = GRP_CLEAN;
        end else if (wanted == GRP_CLEAN && !clean_any) begin
            grp = GRP_DIRTY;
        end
    end
endmodule

// File: rtl/psel_top.sv
module psel_top
    import psel_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_en_i,
    input  logic                     req_write_i,
    input  logic                     req_hit_i,
    input  logic [RANK_W-1:0]        req_way_i,
    input  logic [CNT_W-1:0]         target_i,
    output logic [RANK_W-1:0]        victim_o,
    output logic [WAYS-1:0]          valid_o,
    output logic [WAYS-1:0]          dirty_o,
    output logic [WAYS*RANK_W-1:0]   rank_o,
    output logic [CNT_W-1:0]         dirty_cnt_o
);
    req_t      req;
    way_mask_t valid_q;
    way_mask_t dirty_q;
    rank_vec_t ranks;
    way_mask_t grp_mask [2];
    way_idx_t  grp_old  [2];
    logic      grp_any  [2];
    grp_e      grp_sel;
    way_idx_t  free_way;
    logic      free_any;
    way_idx_t  victim;
    way_idx_t  touch_way;
    way_cnt_t  dirty_cnt;

    assign req = '{en: req_en_i, write: req_write_i, hit: req_hit_i, way: req_way_i};

    assign dirty_cnt = ones_of(valid_q & dirty_q);
    assign grp_mask[GRP_CLEAN] = valid_q & ~dirty_q;
    assign grp_mask[GRP_DIRTY] = valid_q & dirty_q;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_grp
            psel_oldest_pick u_pick (
                .members (grp_mask[g]),
                .ranks   (ranks),
                .oldest  (grp_old[g]),
                .any     (grp_any[g])
            );
        end
    endgenerate

    psel_group_choose u_choose (
        .dirty_cnt (dirty_cnt),
        .target    (target_i),
        .is_write  (req.write),
        .clean_any (grp_any[GRP_CLEAN]),
        .dirty_any (grp_any[GRP_DIRTY]),
        .grp       (grp_sel)
    );

    always_comb begin
        free_way = '0;
        free_any = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_way = way_idx_t'(i);
                free_any = 1'b1;
            end
        end
    end

    assign victim    = free_any ? free_way : grp_old[grp_sel];
    assign touch_way = req.hit ? req.way : victim;

    psel_rank_keeper u_ranks (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (req.en),
        .touch_way (touch_way),
        .ranks     (ranks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (req.en) begin
            if (req.hit) begin
                if (req.write) begin
                    dirty_q[req.way] <= 1'b1;
                end
            end else begin
                valid_q[victim] <= 1'b1;
                dirty_q[victim] <= req.write;
            end
        end
    end

    assign victim_o    = victim;
    assign valid_o     = valid_q;
    assign dirty_o     = dirty_q;
    assign rank_o      = ranks;
    assign dirty_cnt_o = dirty_cnt;
endmodule

// File: rtl/psel_checker.sv
module psel_checker
    import psel_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   req_en_i,
    input logic                   req_write_i,
    input logic                   req_hit_i,
    input logic [RANK_W-1:0]      req_way_i,
    input logic [CNT_W-1:0]       target_i,
    input logic [RANK_W-1:0]      victim_o,
    input logic [WAYS-1:0]        valid_o,
    input logic [WAYS-1:0]        dirty_o,
    input logic [WAYS*RANK_W-1:0] rank_o,
    input logic [CNT_W-1:0]       dirty_cnt_o
);
    way_mask_t seen;
    way_mask_t vd;
    logic      started;

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b1;
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++) begin
            seen[rank_o[i*RANK_W +: RANK_W]] = 1'b1;
        end
        vd = valid_o & dirty_o;
    end

    AST_RANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst || !started)
        &seen) else $error("ranks not a permutation"); // R7

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst || !started)
        (valid_o != '1) |-> !valid_o[victim_o]) else $error("valid way chosen while free exists"); // R2

    AST_OVER_TARGET: assert property (@(posedge clk) disable iff (rst || !started)
        (valid_o == '1 && dirty_cnt_o > target_i) |-> dirty_o[victim_o]) else $error("clean victim over target"); // R3

    AST_UNDER_TARGET: assert property (@(posedge clk) disable iff (rst || !started)
        (valid_o == '1 && dirty_cnt_o < target_i && dirty_o != '1) |-> !dirty_o[victim_o]) else $error("dirty victim under target"); // R4

    AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (rst || !started)
        (req_en_i && req_hit_i) |=> (rank_o[$past(req_way_i)*RANK_W +: RANK_W] == '0)) else $error("hit way not MRU"); // R7

    AST_WRITE_HIT_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst || !started)
        (req_en_i && req_hit_i && req_write_i) |=> ($stable(valid_o) && dirty_o[$past(req_way_i)])) else $error("write hit side effect"); // R8

    AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst || !started)
        (req_en_i && !req_hit_i) |=> (valid_o[$past(victim_o)] && dirty_o[$past(victim_o)] == $past(req_write_i))) else $error("fill wrong"); // R9

    AST_COUNT: assert property (@(posedge clk) disable iff (rst || !started)
        dirty_cnt_o == CNT_W'($countones(vd))) else $error("dirty count wrong"); // R10
endmodule

bind psel_top psel_checker u_psel_checker (.*);

// File: tb/psel_top_tb_top.sv
module psel_top_tb_top;
    localparam int W  = 16;
    localparam int RW = 4;
    localparam int CW = 5;

    localparam int K_VICTIM = 0;
    localparam int K_VALID  = 1;
    localparam int K_DIRTY  = 2;
    localparam int K_RANK   = 3;
    localparam int K_CNT    = 4;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_en = 1'b0;
    logic req_write = 1'b0;
    logic req_hit = 1'b0;
    logic [RW-1:0] req_way = '0;
    logic [CW-1:0] target = '0;
    logic [RW-1:0] victim;
    logic [W-1:0]  valid_w;
    logic [W-1:0]  dirty_w;
    logic [W*RW-1:0] rank_w;
    logic [CW-1:0] dcnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t q[$];

    bit m_valid [W];
    bit m_dirty [W];
    int m_rank  [W];

    always #4 clk = ~clk;

    psel_top dut_i (
        .clk(clk), .rst(rst), .req_en_i(req_en), .req_write_i(req_write),
        .req_hit_i(req_hit), .req_way_i(req_way), .target_i(target),
        .victim_o(victim), .valid_o(valid_w), .dirty_o(dirty_w),
        .rank_o(rank_w), .dirty_cnt_o(dcnt)
    );

    // monitor: pops expected items and compares them with the outputs
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = q.pop_front();
            case (it.kind)
                K_VICTIM: act = 64'(victim);
                K_VALID:  act = 64'(valid_w);
                K_DIRTY:  act = 64'(dirty_w);
                K_RANK:   act = 64'(rank_w);
                default:  act = 64'(dcnt);
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    function automatic int m_count();
        int n = 0;
        for (int i = 0; i < W; i++) if (m_valid[i] && m_dirty[i]) n++;
        return n;
    endfunction

    function automatic int m_oldest(bit want_dirty);
        int best = -1;
        for (int i = 0; i < W; i++)
            if (m_valid[i] && m_dirty[i] == want_dirty && (best < 0 || m_rank[i] > m_rank[best])) best = i;
        return best;
    endfunction

    function automatic int m_victim(bit wr, int tgt);
        int n;
        bit want;
        int v;
        for (int i = 0; i < W; i++) if (!m_valid[i]) return i;
        n = m_count();
        if (n > tgt) want = 1'b1;
        else if (n < tgt) want = 1'b0;
        else want = wr;
        v = m_oldest(want);
        if (v < 0) v = m_oldest(!want);
        return v;
    endfunction

    function automatic void m_touch(int w);
        for (int i = 0; i < W; i++) if (m_rank[i] < m_rank[w]) m_rank[i]++;
        m_rank[w] = 0;
    endfunction

    task automatic push(int kind, logic [63:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic push_state(string tag);
        logic [63:0] r = '0;
        logic [63:0] v = '0;
        logic [63:0] d = '0;
        for (int i = 0; i < W; i++) begin
            r[i*RW +: RW] = RW'(m_rank[i]);
            v[i] = m_valid[i];
            d[i] = m_dirty[i];
        end
        push(K_VALID, v, tag);
        push(K_DIRTY, d, tag);
        push(K_RANK, r, tag);
        push(K_CNT, 64'(m_count()), tag);
    endtask

    // victim probe without a request
    task automatic probe(bit wr, int tgt, string tag);
        @(posedge clk); #1;
        req_en = 1'b0;
        req_write = wr;
        target = CW'(tgt);
        push(K_VICTIM, 64'(m_victim(wr, tgt)), tag);
    endtask

    // driver: applies one request, pushes the victim and the next state
    task automatic access(bit wr, bit hit, int way, int tgt, string vtag, string stag);
        int v;
        @(posedge clk); #1;
        req_en = 1'b1;
        req_write = wr;
        req_hit = hit;
        req_way = RW'(way);
        target = CW'(tgt);
        v = m_victim(wr, tgt);
        if (!hit) push(K_VICTIM, 64'(v), vtag);
        @(posedge clk); #1;
        req_en = 1'b0;
        if (hit) begin
            if (wr) m_dirty[way] = 1'b1;
            m_touch(way);
        end else begin
            m_valid[v] = 1'b1;
            m_dirty[v] = wr;
            m_touch(v);
        end
        push_state(stag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < W; i++) begin
            m_valid[i] = 1'b0;
            m_dirty[i] = 1'b0;
            m_rank[i]  = i;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push_state("R1 reset state");

        // R2/R9: fill the empty set with reads, lowest invalid first
        for (int i = 0; i < W; i++) access(1'b0, 1'b0, 0, 8, "R2 free way first", "R9 fill state");

        // R6: all clean, target 0 and a write: dirty group empty
        probe(1'b1, 0, "R6 dirty group empty");
        probe(1'b0, 0, "R6 read with dirty target 0");

        // write misses build a mixed set
        for (int i = 0; i < 6; i++) access(1'b1, 1'b0, 0, 16, "R4 under target clean victim", "R9 write fill state");

        // R7: read hits reorder ranks
        access(1'b0, 1'b1, 5, 8, "", "R7 read hit rank");
        access(1'b0, 1'b1, 12, 8, "", "R7 second read hit rank");

        // R3 / R4 / R5 across the dirty count (6)
        probe(1'b0, 2, "R3 over target read");
        probe(1'b1, 3, "R3 over target write");
        probe(1'b0, 10, "R4 under target read");
        probe(1'b1, 12, "R4 under target write");
        probe(1'b0, m_count(), "R5 equal read");
        probe(1'b1, m_count(), "R5 equal write");

        // R8: write hits on clean lines with a low target
        for (int i = 0; i < W; i++) begin
            if (!m_dirty[i]) access(1'b1, 1'b1, i, 0, "", "R8 write hit dirty only");
        end

        // R6: every line dirty, tie read would want clean
        probe(1'b0, 16, "R6 clean group empty");
        probe(1'b0, 20, "R6 clean group empty large target");

        // misses under all-dirty, then mixed evictions with varying targets
        for (int i = 0; i < 10; i++) begin
            access(i[0], 1'b0, 0, (i * 3) % 17, "R3 R4 R5 mixed victim", "R10 mixed state");
            access(1'b0, 1'b1, (i * 7) % 16, 8, "", "R7 mixed hit rank");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule